// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog down-counter paced by a slow free-running oscillator rather than by the system clock. The oscillator pin is brought into the system clock domain through a short synchronizer. Each rising edge of the oscillator becomes one slow tick. A power-of-two prescaler divides those ticks, and every divided tick steps the down-counter once. If software fails to refresh the counter before it runs out, the block raises a one-cycle reset request for the system.

Software reaches the block through a small register port with four word addresses. Address 0 is a write-only key register. Address 1 holds a 3-bit prescaler select. Address 2 holds an 11-bit reload value. Address 3 is reserved and reads as zero. The two configuration registers are normally locked. Magic key values unlock them, start the counter, and refresh it. Once started, the watchdog cannot be stopped by software. A debug-halt input freezes counting while a debugger holds the processor.

The control core is a four-state machine with states ST_STOP_LOCK, ST_STOP_OPEN, ST_RUN_LOCK and ST_RUN_OPEN. There are three named transitions. The unlock transition (key 0x5555) goes from a locked state to the open state of the same run mode. The start transition (key 0xCCCC) goes from any state to ST_RUN_LOCK. The relock transition (any other key value, refreshes included) goes from an open state to the locked state of the same run mode. No transition leads from a running state to a stopped state. Only reset returns the machine to ST_STOP_LOCK.

Top module: `wdt_keyed_watchdog`

## Requirements
- R1: After reset the prescaler select reads 0, the reload value reads 0x7FF, the counter is stopped, the configuration is locked and `rst_req` is low.
- R2: While locked, writes to the prescaler (address 1) and reload (address 2) registers leave them unchanged. Writing key 0x5555 to address 0 unlocks them, and writes then take effect.
- R3: A key write of any value other than 0x5555 relocks the configuration registers.
- R4: Key 0xCCCC starts the watchdog. It loads the counter from the reload register, clears the prescaler phase and relocks the configuration. `rst_req` stays low while the watchdog is stopped.
- R5: Once running, `rst_req` pulses after exactly (reload+1) × 2^(prescaler+2) oscillator rising edges. The counter then reloads and the period repeats.
- R6: Key 0xAAAA, while running, reloads the counter from the reload register and clears the prescaler phase. A new reload value takes effect at the next refresh. While stopped, this key only relocks.
- R7: Once running, no key write stops the watchdog.
- R8: While `dbg_halt` is high, oscillator edges do not advance the prescaler or the counter. Counting resumes where it stopped when `dbg_halt` falls.
- R9: Addresses 1 and 2 read back their current values, masked to 3 and 11 bits on write. Addresses 0 and 3 read as zero.
- R10: `rst_req` is high for a single clock cycle per expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Slow oscillator, asynchronous to clk |
| dbg_halt | input | 1 | High while the debugger halts the CPU |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address (0 key, 1 prescaler, 2 reload, 3 reserved) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 3-bit prescaler select, an 11-bit reload value and a two-stage synchronizer. It programs small reload values, so each expiry is reached within a few dozen oscillator edges. The period is probed one edge short of expiry and again exactly at expiry. One run sets the prescaler to 6, which brings the divide-by-256 path within reach in a few thousand clocks. The 0x7FF reset reload is covered only by readback, because running it out would take over eight thousand edges.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_STOP_LOCK = 2'd0,
        ST_STOP_OPEN = 2'd1,
        ST_RUN_LOCK  = 2'd2,
        ST_RUN_OPEN  = 2'd3
    } wdt_state_e;

    localparam logic [15:0] KEY_UNLOCK = 16'h5555;
    localparam logic [15:0] KEY_START  = 16'hCCCC;
    localparam logic [15:0] KEY_KICK   = 16'hAAAA;

    localparam logic [1:0] ADDR_KEY  = 2'd0;
    localparam logic [1:0] ADDR_PRE  = 2'd1;
    localparam logic [1:0] ADDR_RLD  = 2'd2;
    localparam logic [1:0] ADDR_RSVD = 2'd3;

endpackage

// File: rtl/wdt_osc_sync.sv
module wdt_osc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic tick
);
    // STAGES flops for metastability, plus one for edge detection
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-1:0], osc_in};
        end
    end

    assign tick = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              cfg_open,
    output logic              running,
    output logic              start_pulse,
    output logic              kick_pulse
);
    wdt_state_e state_q, state_d;

    logic is_unlock, is_start, is_kick;

    assign is_unlock = key_wr && (key_val == DATA_W'(KEY_UNLOCK));
    assign is_start  = key_wr && (key_val == DATA_W'(KEY_START));
    assign is_kick   = key_wr && (key_val == DATA_W'(KEY_KICK));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP_LOCK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: unlock, start and relock transitions
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                ST_STOP_LOCK: begin
                    if (is_start)       state_d = ST_RUN_LOCK;
                    else if (is_unlock) state_d = ST_STOP_OPEN;
                end
                ST_STOP_OPEN: begin
                    if (is_start)        state_d = ST_RUN_LOCK;
                    else if (!is_unlock) state_d = ST_STOP_LOCK;
                end
                ST_RUN_LOCK: begin
                    if (is_unlock) state_d = ST_RUN_OPEN;
                end
                ST_RUN_OPEN: begin
                    if (!is_unlock) state_d = ST_RUN_LOCK;
                end
                default: state_d = ST_STOP_LOCK;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cfg_open    = 1'b0;
        running     = 1'b0;
        unique case (state_q)
            ST_STOP_LOCK: begin cfg_open = 1'b0; running = 1'b0; end
            ST_STOP_OPEN: begin cfg_open = 1'b1; running = 1'b0; end
            ST_RUN_LOCK:  begin cfg_open = 1'b0; running = 1'b1; end
            ST_RUN_OPEN:  begin cfg_open = 1'b1; running = 1'b1; end
            default:      begin cfg_open = 1'b0; running = 1'b0; end
        endcase
        start_pulse = is_start;
        kick_pulse  = is_kick && running;
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PR_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            enable,
    input  logic            osc_tick,
    input  logic [PR_W-1:0] pr_sel,
    output logic            div_tick
);
    // Largest exponent is (2^PR_W - 1) + 2, so CNT_W bits hold any phase
    localparam int CNT_W = (1 << PR_W) + 1;
    localparam int SH_W  = PR_W + 1;

    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] limit;
    logic [SH_W-1:0]  shamt;
    logic             step;
    logic             at_end;

    assign shamt  = {1'b0, pr_sel} + SH_W'(2);
    assign limit  = (CNT_W'(1) << shamt) - CNT_W'(1);
    assign step   = enable && osc_tick;
    assign at_end = (phase_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= at_end ? '0 : phase_q + CNT_W'(1);
        end
    end

    assign div_tick = step && at_end && !clear;

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int RL_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [RL_W-1:0] reload_val,
    input  logic            div_tick,
    output logic            expire,
    output logic [RL_W-1:0] count
);
    logic [RL_W-1:0] cnt_q;
    logic            exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (load) begin
                cnt_q <= reload_val;
            end else if (div_tick) begin
                if (cnt_q == '0) begin
                    cnt_q <= reload_val;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - RL_W'(1);
                end
            end
        end
    end

    assign expire = exp_q;
    assign count  = cnt_q;

endmodule

// File: rtl/wdt_keyed_watchdog.sv
module wdt_keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int PR_W        = 3,
    parameter int RL_W        = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic              dbg_halt,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    logic [PR_W-1:0] pr_q;
    logic [RL_W-1:0] rl_q;
    logic            cfg_open, running, start_pulse, kick_pulse;
    logic            osc_tick, div_tick, count_en;
    logic [RL_W-1:0] cnt_val;
    logic            key_wr, cfg_wr;

    assign key_wr   = wr_en && (addr == ADDR_KEY);
    assign cfg_wr   = wr_en && cfg_open;
    assign count_en = running && !dbg_halt;

    wdt_osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_in (osc_in),
        .tick   (osc_tick)
    );

    wdt_key_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (key_wr),
        .key_val     (wdata),
        .cfg_open    (cfg_open),
        .running     (running),
        .start_pulse (start_pulse),
        .kick_pulse  (kick_pulse)
    );

    wdt_prescaler #(.PR_W(PR_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_pulse || kick_pulse),
        .enable   (count_en),
        .osc_tick (osc_tick),
        .pr_sel   (pr_q),
        .div_tick (div_tick)
    );

    wdt_down_counter #(.RL_W(RL_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_pulse || kick_pulse),
        .reload_val (rl_q),
        .div_tick   (div_tick),
        .expire     (rst_req),
        .count      (cnt_val)
    );

    // Protected configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q <= '0;
            rl_q <= '1;
        end else if (cfg_wr) begin
            if (addr == ADDR_PRE) pr_q <= wdata[PR_W-1:0];
            if (addr == ADDR_RLD) rl_q <= wdata[RL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_KEY:  rdata = '0;
            ADDR_PRE:  rdata = DATA_W'(pr_q);
            ADDR_RLD:  rdata = DATA_W'(rl_q);
            ADDR_RSVD: rdata = '0;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_keyed_watchdog_chk.sv
module wdt_keyed_watchdog_chk #(
    parameter int DATA_W = 16,
    parameter int PR_W   = 3,
    parameter int RL_W   = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] rdata,
    input logic              dbg_halt,
    input logic              rst_req,
    input logic              cfg_open,
    input logic              running,
    input logic [PR_W-1:0]   pr_q,
    input logic [RL_W-1:0]   rl_q,
    input logic [RL_W-1:0]   cnt
);
    p_locked_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(pr_q));

    p_locked_rld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(rl_q));

    p_quiet_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !rst_req);

    p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dbg_halt && !wr_en) |=> $stable(cnt));

    p_key_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0) |-> (rdata == '0));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

endmodule

bind wdt_keyed_watchdog wdt_keyed_watchdog_chk #(
    .DATA_W (DATA_W),
    .PR_W   (PR_W),
    .RL_W   (RL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .dbg_halt (dbg_halt),
    .rst_req  (rst_req),
    .cfg_open (cfg_open),
    .running  (running),
    .pr_q     (pr_q),
    .rl_q     (rl_q),
    .cnt      (cnt_val)
);

// File: tb/wdt_keyed_watchdog_test.sv
module wdt_keyed_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_in = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int run_len = 0;
    int max_run = 0;

    always #5 clk = ~clk;

    wdt_keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .dbg_halt(dbg_halt),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rst_req(rst_req)
    );

    always @(posedge clk) begin
        if (rst_req) begin
            pulses  <= pulses + 1;
            run_len <= run_len + 1;
            if (run_len + 1 > max_run) max_run <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd3; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            osc_in = 1'b1;
            repeat (4) @(negedge clk);
            osc_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd1, v); check(v == 16'h0, "R1 prescaler reset", v, 0);
        rd(2'd2, v); check(v == 16'h7FF, "R1 reload reset", v, 16'h7FF);
        rd(2'd0, v); check(v == 16'h0, "R9 key reads zero", v, 0);
        check(rst_req == 1'b0, "R1 rst_req low", rst_req, 0);
        edges(20);
        check(pulses == 0, "R4 no pulse while stopped", pulses, 0);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        wr(2'd1, 16'h5);
        rd(2'd1, v); check(v == 16'h0, "R2 locked write ignored", v, 0);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h5);
        rd(2'd1, v); check(v == 16'h5, "R2 unlocked write", v, 5);
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'h2);
        rd(2'd1, v); check(v == 16'h5, "R3 relock by other key", v, 5);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'hFFFF);
        rd(2'd1, v); check(v == 16'h7, "R9 prescaler masked", v, 7);
        rd(2'd2, v); check(v == 16'h7FF, "R9 reload masked", v, 16'h7FF);
        rd(2'd3, v); check(v == 16'h0, "R9 reserved reads zero", v, 0);
        wr(2'd1, 16'h0);
        wr(2'd2, 16'h3);
        wr(2'd0, 16'hAAAA);
        wr(2'd2, 16'h9);
        rd(2'd2, v); check(v == 16'h3, "R6 refresh key relocks while stopped", v, 3);
        edges(20);
        check(pulses == 0, "R6 refresh does not start", pulses, 0);
    endtask

    task automatic t_timeout();
        logic [15:0] v;
        int p0;
        wr(2'd0, 16'hCCCC);
        wr(2'd1, 16'h4);
        rd(2'd1, v); check(v == 16'h0, "R4 start relocks", v, 0);
        p0 = pulses;
        edges(15);
        check(pulses == p0, "R5 no pulse one edge early", pulses, p0);
        edges(1);
        check(pulses == p0 + 1, "R5 pulse at 16 edges", pulses, p0 + 1);
        edges(15);
        check(pulses == p0 + 1, "R5 reload no early repeat", pulses, p0 + 1);
        edges(1);
        check(pulses == p0 + 2, "R5 repeat period", pulses, p0 + 2);
        check(max_run == 1, "R10 single cycle pulse", max_run, 1);
    endtask

    task automatic t_kick();
        int p0;
        p0 = pulses;
        edges(10);
        wr(2'd0, 16'hAAAA);
        edges(15);
        check(pulses == p0, "R6 refresh postpones expiry", pulses, p0);
        edges(1);
        check(pulses == p0 + 1, "R6 expiry after refresh", pulses, p0 + 1);
    endtask

    task automatic t_nostop();
        int p0;
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'h1);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hFFFF);
        wr(2'd0, 16'hAAAA);
        p0 = pulses;
        edges(7);
        check(pulses == p0, "R7 new reload early", pulses, p0);
        edges(1);
        check(pulses == p0 + 1, "R7 still running after junk keys", pulses, p0 + 1);
    endtask

    task automatic t_freeze();
        int p0;
        wr(2'd0, 16'hAAAA);
        p0 = pulses;
        edges(4);
        dbg_halt = 1'b1;
        edges(20);
        check(pulses == p0, "R8 frozen during halt", pulses, p0);
        dbg_halt = 1'b0;
        edges(3);
        check(pulses == p0, "R8 resumes without skip", pulses, p0);
        edges(1);
        check(pulses == p0 + 1, "R8 expiry after resume", pulses, p0 + 1);
    endtask

    task automatic t_bigdiv();
        int p0;
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h6);
        wr(2'd2, 16'h0);
        wr(2'd0, 16'hAAAA);
        p0 = pulses;
        edges(255);
        check(pulses == p0, "R5 divide 256 early", pulses, p0);
        edges(1);
        check(pulses == p0 + 1, "R5 divide 256 expiry", pulses, p0 + 1);
        check(max_run == 1, "R10 single cycle pulse", max_run, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        addr = 2'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_timeout();
        t_kick();
        t_nostop();
        t_freeze();
        t_bigdiv();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule